// File: doc/BRIEF.md
# Add/Subtract Execute Stage with Condition Flags

This block is the integer add/subtract execute stage of a 64-bit load/store processor. Each cycle it can take one decoded operation. The operation gives a destination index and two source indices, an immediate field, a shift selector with an amount, an add/subtract select, a flag-update bit and an operand size bit. The stage reads its register file and forms the second operand in one of two ways: from a 12-bit immediate, or from a register passed through a shifter. It then adds or subtracts. The result is written back to the destination register. The negative, zero, carry and overflow flags are updated when the operation asks for it.

Index 31 is a hardwired zero register. Reading it gives zero, and writes to it are dropped. A compare is therefore just a flag-setting subtract into index 31. In 32-bit mode the stage works on the low halves of the registers and zero-extends the result. The registers start empty after reset, so every value is built with operations of the stage itself, for example an immediate added to the zero register.

Top module: `addsub_exec_unit`

## Requirements
- R1: With use_imm_i=0, shift code 11 and valid_i=1, result_o in the next cycle is rn + rm (sub_i=0) or rn - rm (sub_i=1), modulo 2^64. The value is written to register rd and is read back by any later operation.
- R2: With use_imm_i=1, the second operand is imm12_i zero-extended, shifted left by 12 when imm_sh12_i=1. shift_type_i and shift_amt_i are then ignored.
- R3: With use_imm_i=0, the second register passes through a shifter before the adder. shift_type_i 00 shifts left logically, 01 shifts right logically, 10 shifts right arithmetically and 11 applies no shift. The distance is shift_amt_i.
- R4: Register index 31 reads as zero as either source. A write addressed to index 31 changes no register.
- R5: flags_o is {N,Z,C,V}, with bit 3 = N and bit 0 = V. An operation with set_flags_i=1 loads the new flags into flags_o in the next cycle. With set_flags_i=0 the flags keep their value.
- R6: N equals the top bit of the result at the active width. Z is 1 exactly when the result at the active width is zero.
- R7: On add, C is the carry out of the active width. On subtract, C is 1 when rn >= operand 2 unsigned (no borrow). V is 1 on signed overflow at the active width.
- R8: With is64_i=0, both operands are the low 32 bits, the shifts act on 32-bit values, and the result is zero-extended into bits 63:32 on result_o and in the register.
- R9: A register-form operation with is64_i=0 and shift_amt_i > 31 raises illegal_o in the next cycle. It writes no register, leaves the flags unchanged and drives result_o to zero.
- R10: A flag-setting subtract with rd = 31 (compare) updates only the flags and changes no register.
- R11: After reset, all registers read zero and result_o, flags_o, valid_o and illegal_o are zero.
- R12: valid_o is valid_i delayed by one cycle. While valid_i=0, result_o and flags_o hold and illegal_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| rd_idx_i | input | 5 | Destination register index |
| rn_idx_i | input | 5 | First source register index |
| rm_idx_i | input | 5 | Second source register index |
| use_imm_i | input | 1 | 1: immediate operand, 0: shifted register |
| imm12_i | input | 12 | Unsigned immediate |
| imm_sh12_i | input | 1 | Shift immediate left by 12 |
| shift_type_i | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 none |
| shift_amt_i | input | 6 | Shift distance |
| sub_i | input | 1 | 1: subtract, 0: add |
| set_flags_i | input | 1 | Update flags |
| is64_i | input | 1 | 1: 64-bit, 0: 32-bit |
| valid_o | output | 1 | Result registered this cycle |
| illegal_o | output | 1 | Last operation had an illegal encoding |
| result_o | output | 64 | Registered result |
| flags_o | output | 4 | {N,Z,C,V} |

## Verification
Directed operations build large values from small immediates and shifts. These operations separate the three shift kinds, the two immediate scalings and both operand widths. The flag cases are chosen to tell carry from overflow: all-ones plus one, zero minus one, and the largest positive value plus one. Compare-into-zero-register, write-to-zero-register and illegal 32-bit shift operations are each followed by a read of the register they could have touched. A long stream of random operations, including back-to-back dependent ones, checks every output against a behavioural model on every cycle.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    SH_LSL  = 2'b00,
    SH_LSR  = 2'b01,
    SH_ASR  = 2'b10,
    SH_NONE = 2'b11
  } shift_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/addsub_regfile.sv
module addsub_regfile #(
  parameter int XLEN  = 64,
  parameter int NREGS = 32,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wa_i,
  input  logic [XLEN-1:0]  wd_i,
  input  logic [IDX_W-1:0] ra_i,
  input  logic [IDX_W-1:0] rb_i,
  output logic [XLEN-1:0]  rda_o,
  output logic [XLEN-1:0]  rdb_o
);
  // top index has no storage: it is the zero register
  logic [XLEN-1:0] mem [NREGS-1];

  for (genvar g = 0; g < NREGS - 1; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[g] <= '0;
      else if (we_i && wa_i == IDX_W'(g)) mem[g] <= wd_i;
    end
  end

  always_comb begin
    rda_o = '0;
    rdb_o = '0;
    for (int i = 0; i < NREGS - 1; i++) begin
      if (ra_i == IDX_W'(i)) rda_o = mem[i];
      if (rb_i == IDX_W'(i)) rdb_o = mem[i];
    end
  end
endmodule

// File: rtl/addsub_shifter.sv
module addsub_shifter
  import addsub_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int AMT_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  val_i,
  input  logic [1:0]       kind_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             is64_i,
  output logic [XLEN-1:0]  val_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0]  src;
  logic [AMT_W-1:0] amt;
  logic [XLEN-1:0]  shl, shr, sar;

  // narrow mode: operate on the low half, sign taken from its top bit
  always_comb begin
    if (is64_i) begin
      src = val_i;
      amt = amt_i;
    end else begin
      src = {{HALF{val_i[HALF-1]}}, val_i[HALF-1:0]};
      amt = {1'b0, amt_i[AMT_W-2:0]};
    end
  end

  assign shl = src << amt;
  assign sar = $unsigned($signed(src) >>> amt);
  assign shr = is64_i ? (src >> amt) : ({{HALF{1'b0}}, src[HALF-1:0]} >> amt);

  always_comb begin
    unique case (shift_e'(kind_i))
      SH_LSL:  val_o = shl;
      SH_LSR:  val_o = shr;
      SH_ASR:  val_o = sar;
      default: val_o = src;
    endcase
    if (!is64_i) val_o = {{HALF{1'b0}}, val_o[HALF-1:0]};
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core
  import addsub_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  input  logic            is64_i,
  output logic [XLEN-1:0] res_o,
  output nzcv_t           flags_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] b_eff;
  logic [XLEN:0]   sum_w;
  logic [HALF:0]   sum_h;

  // subtract = a + ~b + 1; carry out is then the no-borrow flag
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_w = {1'b0, a_i} + {1'b0, b_eff} + (XLEN+1)'(sub_i);
  assign sum_h = {1'b0, a_i[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + (HALF+1)'(sub_i);

  always_comb begin
    if (is64_i) begin
      res_o     = sum_w[XLEN-1:0];
      flags_o.n = sum_w[XLEN-1];
      flags_o.z = ~|sum_w[XLEN-1:0];
      flags_o.c = sum_w[XLEN];
      flags_o.v = (a_i[XLEN-1] == b_eff[XLEN-1]) && (sum_w[XLEN-1] != a_i[XLEN-1]);
    end else begin
      res_o     = {{HALF{1'b0}}, sum_h[HALF-1:0]};
      flags_o.n = sum_h[HALF-1];
      flags_o.z = ~|sum_h[HALF-1:0];
      flags_o.c = sum_h[HALF];
      flags_o.v = (a_i[HALF-1] == b_eff[HALF-1]) && (sum_h[HALF-1] != a_i[HALF-1]);
    end
  end
endmodule

// File: rtl/addsub_exec_unit.sv
module addsub_exec_unit
  import addsub_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int NREGS     = 32,
  parameter int IMM_W     = 12,
  parameter int IMM_SHIFT = 12,
  parameter int IDX_W     = $clog2(NREGS),
  parameter int AMT_W     = $clog2(XLEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [IDX_W-1:0] rn_idx_i,
  input  logic [IDX_W-1:0] rm_idx_i,
  input  logic             use_imm_i,
  input  logic [IMM_W-1:0] imm12_i,
  input  logic             imm_sh12_i,
  input  logic [1:0]       shift_type_i,
  input  logic [AMT_W-1:0] shift_amt_i,
  input  logic             sub_i,
  input  logic             set_flags_i,
  input  logic             is64_i,
  output logic             valid_o,
  output logic             illegal_o,
  output logic [XLEN-1:0]  result_o,
  output logic [3:0]       flags_o
);
  localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(NREGS - 1);

  logic [XLEN-1:0] rn_val, rm_val, rm_shifted, imm_val, op2, sum;
  nzcv_t           new_flags, flags_q;
  logic            illegal, wr_en;

  addsub_regfile #(.XLEN(XLEN), .NREGS(NREGS), .IDX_W(IDX_W)) i_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr_en),
    .wa_i  (rd_idx_i),
    .wd_i  (sum),
    .ra_i  (rn_idx_i),
    .rb_i  (rm_idx_i),
    .rda_o (rn_val),
    .rdb_o (rm_val)
  );

  addsub_shifter #(.XLEN(XLEN), .AMT_W(AMT_W)) i_shift (
    .val_i (rm_val),
    .kind_i(shift_type_i),
    .amt_i (shift_amt_i),
    .is64_i(is64_i),
    .val_o (rm_shifted)
  );

  assign imm_val = XLEN'(imm12_i) << (imm_sh12_i ? IMM_SHIFT : 0);
  assign op2     = use_imm_i ? imm_val : rm_shifted;

  addsub_core #(.XLEN(XLEN)) i_core (
    .a_i    (rn_val),
    .b_i    (op2),
    .sub_i  (sub_i),
    .is64_i (is64_i),
    .res_o  (sum),
    .flags_o(new_flags)
  );

  // narrow-mode register shift beyond half width is an illegal encoding
  assign illegal = !use_imm_i && !is64_i && shift_amt_i[AMT_W-1];
  assign wr_en   = valid_i && !illegal && (rd_idx_i != ZERO_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
      flags_q   <= '0;
    end else begin
      valid_o   <= valid_i;
      illegal_o <= valid_i && illegal;
      if (valid_i) begin
        result_o <= illegal ? '0 : sum;
        if (set_flags_i && !illegal) flags_q <= new_flags;
      end
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/addsub_exec_checker.sv
module addsub_exec_checker #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5,
  parameter int AMT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic             use_imm_i,
  input logic [AMT_W-1:0] shift_amt_i,
  input logic             set_flags_i,
  input logic             is64_i,
  input logic             valid_o,
  input logic             illegal_o,
  input logic [XLEN-1:0]  result_o,
  input logic [3:0]       flags_o
);
  localparam int HALF = XLEN / 2;

  a_r12_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(flags_o) && !illegal_o));

  a_r5_flags_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !set_flags_i) |=> $stable(flags_o));

  a_r9_illegal_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !use_imm_i && !is64_i && shift_amt_i > AMT_W'(HALF - 1))
      |=> (illegal_o && result_o == '0 && $stable(flags_o)));

  a_r8_zero_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is64_i) |=> (result_o[XLEN-1:HALF] == '0));

  a_r6_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && set_flags_i && is64_i) |=> (illegal_o || flags_o[2] == (result_o == '0)));

  a_r6_neg_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && set_flags_i && is64_i) |=> (flags_o[3] == result_o[XLEN-1]));

  a_r10_rd_sink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rd_idx_i == '1) |=> valid_o);
endmodule

bind addsub_exec_unit addsub_exec_checker #(
  .XLEN(XLEN), .IDX_W(IDX_W), .AMT_W(AMT_W)
) i_addsub_exec_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .rd_idx_i    (rd_idx_i),
  .use_imm_i   (use_imm_i),
  .shift_amt_i (shift_amt_i),
  .set_flags_i (set_flags_i),
  .is64_i      (is64_i),
  .valid_o     (valid_o),
  .illegal_o   (illegal_o),
  .result_o    (result_o),
  .flags_o     (flags_o)
);

// File: tb/test_addsub_exec_unit.sv
`timescale 1ns/1ps
module test_addsub_exec_unit;
  localparam time CLK_P = 20ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  rd_idx_i = '0, rn_idx_i = '0, rm_idx_i = '0;
  logic        use_imm_i = 1'b0;
  logic [11:0] imm12_i = '0;
  logic        imm_sh12_i = 1'b0;
  logic [1:0]  shift_type_i = '0;
  logic [5:0]  shift_amt_i = '0;
  logic        sub_i = 1'b0, set_flags_i = 1'b0, is64_i = 1'b1;
  logic        valid_o, illegal_o;
  logic [63:0] result_o;
  logic [3:0]  flags_o;

  int total = 0;
  int bad   = 0;

  logic [63:0] mrf [32];
  logic [3:0]  mflags = '0;
  logic [63:0] mres = '0;

  always #(CLK_P/2) clk_i = ~clk_i;

  addsub_exec_unit i_addsub_exec_unit (
    .clk_i, .rst_ni, .valid_i, .rd_idx_i, .rn_idx_i, .rm_idx_i, .use_imm_i,
    .imm12_i, .imm_sh12_i, .shift_type_i, .shift_amt_i, .sub_i, .set_flags_i,
    .is64_i, .valid_o, .illegal_o, .result_o, .flags_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation: drive at a falling edge, check at the next falling edge
  task automatic op(input string req, input bit imm, input bit [4:0] rd, input bit [4:0] rn,
                    input bit [4:0] rm, input bit [11:0] iv, input bit sh,
                    input bit [1:0] st, input bit [5:0] amt, input bit sb,
                    input bit sf, input bit w64);
    logic [63:0] a, rmv, b, r;
    logic [31:0] b32, r32;
    logic c, v, ill;
    logic [3:0] ef;
    a   = (rn == 31) ? 64'd0 : mrf[rn];
    rmv = (rm == 31) ? 64'd0 : mrf[rm];
    ill = !imm && !w64 && amt > 31;
    if (imm) b = {52'd0, iv} << (sh ? 12 : 0);
    else if (w64) begin
      case (st)
        2'b00:   b = rmv << amt;
        2'b01:   b = rmv >> amt;
        2'b10:   b = $unsigned($signed(rmv) >>> amt);
        default: b = rmv;
      endcase
    end else begin
      case (st)
        2'b00:   b32 = rmv[31:0] << amt[4:0];
        2'b01:   b32 = rmv[31:0] >> amt[4:0];
        2'b10:   b32 = $unsigned($signed(rmv[31:0]) >>> amt[4:0]);
        default: b32 = rmv[31:0];
      endcase
      b = {32'd0, b32};
    end
    if (w64) begin
      r = sb ? a - b : a + b;
      c = sb ? (a >= b) : (r < a);
      v = sb ? (a[63] != b[63] && r[63] != a[63]) : (a[63] == b[63] && r[63] != a[63]);
      ef = {r[63], r == 0, c, v};
    end else begin
      r32 = sb ? a[31:0] - b[31:0] : a[31:0] + b[31:0];
      c = sb ? (a[31:0] >= b[31:0]) : (r32 < a[31:0]);
      v = sb ? (a[31] != b[31] && r32[31] != a[31]) : (a[31] == b[31] && r32[31] != a[31]);
      ef = {r32[31], r32 == 0, c, v};
      r = {32'd0, r32};
    end
    if (ill || !sf) ef = mflags;
    if (ill) r = '0;
    valid_i = 1'b1; use_imm_i = imm; rd_idx_i = rd; rn_idx_i = rn; rm_idx_i = rm;
    imm12_i = iv; imm_sh12_i = sh; shift_type_i = st; shift_amt_i = amt;
    sub_i = sb; set_flags_i = sf; is64_i = w64;
    @(negedge clk_i);
    chk({req, " valid"}, 64'(valid_o), 64'd1);
    chk({req, " illegal"}, 64'(illegal_o), 64'(ill));
    chk({req, " result"}, result_o, r);
    chk({req, " flags"}, 64'(flags_o), 64'(ef));
    if (!ill && rd != 31) mrf[rd] = r;
    mflags = ef;
    mres = r;
  endtask

  task automatic idle(input string req);
    valid_i = 1'b0;
    rd_idx_i = 5'd3; set_flags_i = 1'b1; shift_amt_i = 6'd40; is64_i = 1'b0;
    @(negedge clk_i);
    chk({req, " valid"}, 64'(valid_o), 64'd0);
    chk({req, " illegal"}, 64'(illegal_o), 64'd0);
    chk({req, " result hold"}, result_o, mres);
    chk({req, " flags hold"}, 64'(flags_o), 64'(mflags));
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    for (int i = 0; i < 32; i++) mrf[i] = '0;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 result", result_o, 64'd0);
    chk("R11 flags", 64'(flags_o), 64'd0);
    chk("R11 valid", 64'(valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    op("R11 reg5 empty", 0, 0, 5, 31, 0, 0, 3, 0, 0, 0, 1);
    // R2 immediate forms
    op("R2 imm 4095",     1, 1, 31, 0, 12'hfff, 0, 2'b00, 6'd63, 0, 0, 1);
    op("R2 imm 1 sh12",   1, 2, 31, 0, 12'h001, 1, 2'b01, 6'd5,  0, 0, 1);
    // R1 register form
    op("R1 add",          0, 3, 1, 2, 0, 0, 3, 0, 0, 0, 1);
    op("R1 sub neg",      0, 4, 1, 2, 0, 0, 3, 0, 1, 0, 1);
    // R3 shifts
    op("R3 lsl 40",       0, 5, 31, 3, 0, 0, 2'b00, 6'd40, 0, 0, 1);
    op("R3 lsr 3",        0, 6, 31, 5, 0, 0, 2'b01, 6'd3,  0, 0, 1);
    op("R3 asr 8",        0, 7, 31, 4, 0, 0, 2'b10, 6'd8,  0, 0, 1);
    op("R3 none",         0, 8, 31, 3, 0, 0, 2'b11, 6'd10, 0, 0, 1);
    // R7 carry and overflow, R6 N/Z
    op("R7 zero minus one",  1, 9,  31, 0, 12'd1, 0, 0, 0, 1, 1, 1);
    op("R7 ones plus one",   1, 10, 9,  0, 12'd1, 0, 0, 0, 0, 1, 1);
    op("R7 max pos",         0, 11, 31, 9, 0, 0, 2'b01, 6'd1, 0, 1, 1);
    op("R7 add overflow",    1, 12, 11, 0, 12'd1, 0, 0, 0, 0, 1, 1);
    op("R7 sub overflow",    1, 13, 12, 0, 12'd1, 0, 0, 0, 1, 1, 1);
    // R5 plain op keeps flags
    op("R5 no flag update",  1, 14, 31, 0, 12'd0, 0, 0, 0, 0, 0, 1);
    // R10 compare equal, then read zero register
    op("R10 cmp",            1, 31, 1, 0, 12'hfff, 0, 0, 0, 1, 1, 1);
    op("R10 x1 intact",      0, 15, 1, 31, 0, 0, 3, 0, 0, 0, 1);
    // R4 write to zero register then read it
    op("R4 write 31",        1, 31, 31, 0, 12'h777, 1, 0, 0, 0, 0, 1);
    op("R4 read 31",         0, 16, 31, 31, 0, 0, 3, 0, 0, 1, 1);
    // R8 narrow mode
    op("R8 w ones plus one", 1, 17, 9, 0, 12'd1, 0, 0, 0, 0, 1, 0);
    op("R8 w asr",           0, 18, 31, 9, 0, 0, 2'b10, 6'd4, 0, 1, 0);
    op("R8 w sub",           0, 19, 3, 5, 0, 0, 2'b01, 6'd31, 1, 1, 0);
    // R9 illegal narrow shift, then read the target
    op("R9 illegal",         0, 1, 3, 2, 0, 0, 2'b00, 6'd40, 0, 1, 0);
    op("R9 x1 unchanged",    0, 20, 1, 31, 0, 0, 3, 0, 0, 0, 1);
    // R12 idle cycles
    idle("R12 idle");
    idle("R12 idle 2");
    // random stream, R1 R3 R7 R8
    seed = 32'h1234_5678;
    void'($urandom(seed));
    for (int k = 0; k < 600; k++) begin
      bit [31:0] x;
      x = $urandom;
      op("R1 R3 R7 R8 random", x[0], 5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)),
         5'($urandom_range(0, 31)), 12'($urandom), x[1], x[3:2],
         x[4] ? 6'($urandom_range(0, 31)) : 6'($urandom), x[5], x[6], x[7] | x[8]);
      if (x[9] && x[10] && x[11]) idle("R12 random idle");
    end
    valid_i = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule